// File: doc/BRIEF.md
# Pipe Response and Sequence-Toggle Controller

This block holds the per-pipe control state that a USB protocol engine consults before and after each transaction on one endpoint pipe. It keeps three things. The first is the DATA0/DATA1 sequence value expected on the next transaction. The second is a flag that marks a transaction as in flight. The third is a two-bit response type, written by software, that says whether the pipe answers with NAK, moves data (BUF) or answers with STALL.

The protocol engine drives one-cycle event strobes into the block:

- a transaction has started;
- a transaction completed normally;
- a received data PID did not match the expected toggle;
- a split-start was issued;
- the matching complete-split finished.

Software writes the response field through a simple write strobe. It can also force the toggle to DATA0 or DATA1 while the pipe is idle. The block presents two response values. One is the register value that software reads back. The other is the effective response, which the engine acts on. While a split transaction is open, the effective response stays frozen, so a late rewrite to NAK cannot cut the split short.

Top module: `pipe_resp_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `toggle`=0 (DATA0), `busy`=0, `resp_reg`=00, `resp_eff`=00 and `split_active`=0.
- R2: The response encoding is 00 NAK, 01 BUF, 10 STALL and 11 STALL. A `cfg_wr` pulse loads `cfg_resp` into `resp_reg` on the following cycle, even while a split is open.
- R3: `ev_start` while `busy`=0 and `resp_eff`=01 sets `busy` on the next cycle. With `resp_eff` at NAK or STALL, `ev_start` leaves `busy` at 0.
- R4: While `busy`=1, a pulse on `ev_done` or `ev_rx_mismatch` clears `busy` on the next cycle.
- R5: On a pipe with `cfg_iso`=0, `ev_done` while `busy`=1 inverts `toggle` on the next cycle. `ev_done` while `busy`=0 leaves `toggle` unchanged.
- R6: `ev_rx_mismatch` leaves `toggle` unchanged, even when `ev_done` is pulsed in the same cycle.
- R7: With `cfg_iso`=1, `ev_done` clears `busy` and leaves `toggle` unchanged.
- R8: While `busy`=0, `tog_clr` sets `toggle` to 0 and `tog_set` sets it to 1 on the next cycle. If both are pulsed together, `tog_clr` wins. While `busy`=1, both strobes are ignored.
- R9: `ev_split_start` sets `split_active` on the next cycle, and `ev_split_done` clears it on the next cycle.
- R10: While `split_active`=1, `resp_eff` holds the value `resp_reg` had in the cycle `ev_split_start` was pulsed. When `split_active` is 0, `resp_eff` equals `resp_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the response field |
| cfg_resp | input | 2 | Response value to write (00 NAK, 01 BUF, 1x STALL) |
| cfg_iso | input | 1 | Pipe is isochronous (no toggle advance) |
| tog_clr | input | 1 | Software strobe: force toggle to DATA0 |
| tog_set | input | 1 | Software strobe: force toggle to DATA1 |
| ev_start | input | 1 | Engine: transaction started |
| ev_done | input | 1 | Engine: transaction completed normally |
| ev_rx_mismatch | input | 1 | Engine: received data PID disagreed with toggle |
| ev_split_start | input | 1 | Engine: split-start issued |
| ev_split_done | input | 1 | Engine: complete-split finished |
| resp_reg | output | 2 | Readable response field |
| resp_eff | output | 2 | Response the engine uses next |
| toggle | output | 1 | Expected sequence toggle (0 DATA0, 1 DATA1) |
| busy | output | 1 | Transaction in flight on the pipe |
| split_active | output | 1 | Split transaction open |

## Verification
The bench targets a NAK rewrite that arrives while a split is open, including a write in the very cycle the split starts. A design that captured the new value would drop `resp_eff` to NAK too early. It also pulses a mismatch together with a normal completion, and it pulses completion on an isochronous pipe. A design that advanced the toggle in either case would lose DATA0/DATA1 alignment with the peer. Toggle forces are pulsed during a transaction and as a clear/set pair, and starts are pulsed under NAK and STALL. These catch a design that corrupts the sequence bit while a transaction is in flight, or one that marks a non-transferring pipe as busy.

// File: rtl/prc_pkg.sv
// Package: shared encodings for the pipe response/toggle controller.
// Assumes a two-bit response field; both upper codes decode as STALL.
package prc_pkg;
    localparam int RESP_W = 2;

    typedef enum logic [RESP_W-1:0] {
        RESP_NAK    = 2'b00,
        RESP_BUF    = 2'b01,
        RESP_STALL  = 2'b10,
        RESP_STALL2 = 2'b11
    } resp_e;

    // True when the response lets the pipe move data.
    function automatic logic resp_moves_data(input logic [RESP_W-1:0] r);
        return r == RESP_BUF;
    endfunction
endpackage

// File: rtl/prc_busy.sv
// Module: transaction-in-flight flag.
// Sets on an accepted start (idle and data allowed) and clears when the
// engine reports completion or a PID mismatch. Assumes one-cycle strobes.
module prc_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    input  logic mismatch,
    input  logic may_move,
    output logic busy
);
    logic accept;
    logic finish;

    // Decode which strobes act on the flag in this cycle.
    always_comb begin
        accept = start & ~busy & may_move;
        finish = busy & (done | mismatch);
    end

    // Hold the in-flight flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (finish)
            busy <= 1'b0;
        else if (accept)
            busy <= 1'b1;
    end
endmodule

// File: rtl/prc_toggle.sv
// Module: expected DATA0/DATA1 sequence bit.
// Advances on a normal completion of a busy, non-isochronous pipe, except
// when a PID mismatch is flagged in the same cycle. Software forces apply
// only while idle; the clear wins over the set.
module prc_toggle #(
    parameter logic TOG_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic done,
    input  logic mismatch,
    input  logic iso,
    input  logic force_clr,
    input  logic force_set,
    output logic toggle
);
    logic advance;
    logic toggle_nxt;

    // Decide whether a completed transaction moves the sequence bit.
    always_comb begin
        advance = busy & done & ~mismatch & ~iso;
    end

    // Select the next sequence value from advance and idle-time forces.
    always_comb begin
        toggle_nxt = toggle;
        if (busy) begin
            if (advance)
                toggle_nxt = ~toggle;
        end else if (force_clr) begin
            toggle_nxt = 1'b0;
        end else if (force_set) begin
            toggle_nxt = 1'b1;
        end
    end

    // Register the sequence bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            toggle <= TOG_RESET;
        else
            toggle <= toggle_nxt;
    end
endmodule

// File: rtl/prc_resp_hold.sv
// Module: readable response field plus the effective response seen by the
// engine. A shadow copy tracks the field while no split is open and is
// frozen from the split-start cycle until the complete-split finishes.
module prc_resp_hold #(
    parameter int W = prc_pkg::RESP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         split_start,
    input  logic         split_done,
    output logic [W-1:0] field_q,
    output logic [W-1:0] eff,
    output logic         split_active
);
    logic [W-1:0] shadow_q;

    // Software-visible field: every write lands at once.
    always_ff @(posedge clk) begin
        if (!rst_n)
            field_q <= '0;
        else if (wr)
            field_q <= wdata;
    end

    // Split-open flag: a finish wins over a new start in an open split.
    always_ff @(posedge clk) begin
        if (!rst_n)
            split_active <= 1'b0;
        else if (split_active && split_done)
            split_active <= 1'b0;
        else if (split_start)
            split_active <= 1'b1;
    end

    // Shadow follows the field until a split freezes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (!split_active)
            shadow_q <= field_q;
    end

    // Effective response: frozen copy during a split, live field otherwise.
    always_comb begin
        eff = split_active ? shadow_q : field_q;
    end
endmodule

// File: rtl/pipe_resp_ctrl.sv
// Module: per-pipe response and sequence-toggle controller (top).
// Combines the response field, the busy flag and the toggle tracker.
// Assumes all event and software strobes are single-cycle pulses that are
// synchronous to clk.
module pipe_resp_ctrl #(
    parameter int   RESP_W    = prc_pkg::RESP_W,
    parameter logic TOG_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [RESP_W-1:0] cfg_resp,
    input  logic              cfg_iso,
    input  logic              tog_clr,
    input  logic              tog_set,
    input  logic              ev_start,
    input  logic              ev_done,
    input  logic              ev_rx_mismatch,
    input  logic              ev_split_start,
    input  logic              ev_split_done,
    output logic [RESP_W-1:0] resp_reg,
    output logic [RESP_W-1:0] resp_eff,
    output logic              toggle,
    output logic              busy,
    output logic              split_active
);
    logic may_move;

    // Only the BUF response lets a start claim the pipe.
    always_comb begin
        may_move = prc_pkg::resp_moves_data(resp_eff);
    end

    prc_resp_hold #(.W(RESP_W)) i_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (cfg_wr),
        .wdata        (cfg_resp),
        .split_start  (ev_split_start),
        .split_done   (ev_split_done),
        .field_q      (resp_reg),
        .eff          (resp_eff),
        .split_active (split_active)
    );

    prc_busy i_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ev_start),
        .done     (ev_done),
        .mismatch (ev_rx_mismatch),
        .may_move (may_move),
        .busy     (busy)
    );

    prc_toggle #(.TOG_RESET(TOG_RESET)) i_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .done      (ev_done),
        .mismatch  (ev_rx_mismatch),
        .iso       (cfg_iso),
        .force_clr (tog_clr),
        .force_set (tog_set),
        .toggle    (toggle)
    );
endmodule

// File: rtl/prc_checker.sv
// Module: property checker bound to pipe_resp_ctrl; observes ports only.
module prc_checker #(
    parameter int RESP_W = prc_pkg::RESP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [RESP_W-1:0] cfg_resp,
    input logic              cfg_iso,
    input logic              ev_start,
    input logic              ev_done,
    input logic              ev_rx_mismatch,
    input logic              ev_split_start,
    input logic              ev_split_done,
    input logic [RESP_W-1:0] resp_reg,
    input logic [RESP_W-1:0] resp_eff,
    input logic              toggle,
    input logic              busy,
    input logic              split_active
);
    import prc_pkg::*;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> resp_reg == $past(cfg_resp)); // R2
    AST_START_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ev_start && resp_eff == RESP_BUF) |=> busy); // R3
    AST_START_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ev_start && resp_eff != RESP_BUF) |=> !busy); // R3
    AST_END_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (ev_done || ev_rx_mismatch)) |=> !busy); // R4
    AST_TOG_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ev_done && !ev_rx_mismatch && !cfg_iso) |=> toggle != $past(toggle)); // R5
    AST_TOG_MISMATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ev_rx_mismatch) |=> $stable(toggle)); // R6
    AST_TOG_ISO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_iso) |=> $stable(toggle)); // R7
    AST_SPLIT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_split_start && !split_active) |=> split_active); // R9
    AST_SPLIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (split_active && ev_split_done) |=> !split_active); // R9
    AST_EFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (split_active && !ev_split_done) |=> $stable(resp_eff)); // R10
    AST_EFF_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !split_active |-> resp_eff == resp_reg); // R10
endmodule

bind pipe_resp_ctrl prc_checker #(.RESP_W(RESP_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_resp       (cfg_resp),
    .cfg_iso        (cfg_iso),
    .ev_start       (ev_start),
    .ev_done        (ev_done),
    .ev_rx_mismatch (ev_rx_mismatch),
    .ev_split_start (ev_split_start),
    .ev_split_done  (ev_split_done),
    .resp_reg       (resp_reg),
    .resp_eff       (resp_eff),
    .toggle         (toggle),
    .busy           (busy),
    .split_active   (split_active)
);

// File: tb/test_pipe_resp_ctrl.sv
// Bench: vector table walked once, then directed reset checks.
module test_pipe_resp_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 28;

    typedef struct packed {
        logic [3:0] req;
        logic       wr;
        logic [1:0] resp;
        logic       iso, tclr, tset, start, done, mis, sst, sdn;
        logic       x_tog, x_busy;
        logic [1:0] x_reg, x_eff;
        logic       x_split;
    } vec_t;

    // Fields: req | wr resp iso tclr tset start done mis sst sdn | tog busy reg eff split
    localparam vec_t TBL [NVEC] = '{
        '{4'd1, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0,1'b0}, // R1 idle
        '{4'd3, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0,1'b0}, // R3 start under NAK
        '{4'd2, 1'b1,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd1,2'd1,1'b0}, // R2 write BUF
        '{4'd3, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,2'd1,2'd1,1'b0}, // R3 start under BUF
        '{4'd8, 1'b0,2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,2'd1,2'd1,1'b0}, // R8 force while busy
        '{4'd4, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd1,2'd1,1'b0}, // R4 done frees, toggles
        '{4'd3, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd1,2'd1,1'b0}, // R3
        '{4'd6, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,2'd1,2'd1,1'b0}, // R6 mismatch
        '{4'd3, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd1,2'd1,1'b0}, // R3
        '{4'd6, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0,2'd1,2'd1,1'b0}, // R6 done+mismatch
        '{4'd5, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd1,2'd1,1'b0}, // R5 done while idle
        '{4'd8, 1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd1,2'd1,1'b0}, // R8 clear
        '{4'd8, 1'b0,2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd1,2'd1,1'b0}, // R8 clear wins
        '{4'd8, 1'b0,2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd1,2'd1,1'b0}, // R8 set
        '{4'd2, 1'b1,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd2,2'd2,1'b0}, // R2 write STALL
        '{4'd3, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd2,2'd2,1'b0}, // R3 start under STALL
        '{4'd2, 1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd3,2'd3,1'b0}, // R2 write 11
        '{4'd2, 1'b1,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd1,2'd1,1'b0}, // R2 back to BUF
        '{4'd7, 1'b0,2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd1,2'd1,1'b0}, // R7 iso start
        '{4'd7, 1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd1,2'd1,1'b0}, // R7 iso done
        '{4'd9, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,2'd1,2'd1,1'b1}, // R9 split opens
        '{4'd10,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,2'd0,2'd1,1'b1}, // R10 NAK write held
        '{4'd10,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,2'd0,2'd1,1'b1}, // R10 start still allowed
        '{4'd5, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd1,1'b1}, // R5 toggle back
        '{4'd9, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,2'd0,2'd0,1'b0}, // R9 split closes
        '{4'd3, 1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,2'd0,2'd0,1'b0}, // R3 NAK now live
        '{4'd10,1'b1,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,2'd1,2'd0,1'b1}, // R10 write in split-start cycle
        '{4'd10,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,2'd1,2'd1,1'b0}  // R10 release
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_wr, cfg_iso, tog_clr, tog_set;
    logic [1:0] cfg_resp;
    logic       ev_start, ev_done, ev_rx_mismatch, ev_split_start, ev_split_done;
    logic [1:0] resp_reg, resp_eff;
    logic       toggle, busy, split_active;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_resp_ctrl i_pipe_resp_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_resp(cfg_resp),
        .cfg_iso(cfg_iso), .tog_clr(tog_clr), .tog_set(tog_set),
        .ev_start(ev_start), .ev_done(ev_done), .ev_rx_mismatch(ev_rx_mismatch),
        .ev_split_start(ev_split_start), .ev_split_done(ev_split_done),
        .resp_reg(resp_reg), .resp_eff(resp_eff), .toggle(toggle),
        .busy(busy), .split_active(split_active)
    );

    task automatic drive_idle();
        cfg_wr = 0; cfg_resp = 0; cfg_iso = 0; tog_clr = 0; tog_set = 0;
        ev_start = 0; ev_done = 0; ev_rx_mismatch = 0;
        ev_split_start = 0; ev_split_done = 0;
    endtask

    // Compare all outputs against an expected set; tag names the requirement.
    task automatic check_all(input string tag, input logic xt, input logic xb,
                             input logic [1:0] xr, input logic [1:0] xe, input logic xs);
        checks++;
        if (toggle !== xt || busy !== xb || resp_reg !== xr || resp_eff !== xe || split_active !== xs) begin
            errors++;
            $display("FAIL %s: got tog=%b busy=%b reg=%b eff=%b split=%b, expected tog=%b busy=%b reg=%b eff=%b split=%b",
                     tag, toggle, busy, resp_reg, resp_eff, split_active, xt, xb, xr, xe, xs);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        drive_idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 reset state", 0, 0, 2'd0, 2'd0, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            cfg_wr = TBL[i].wr; cfg_resp = TBL[i].resp; cfg_iso = TBL[i].iso;
            tog_clr = TBL[i].tclr; tog_set = TBL[i].tset;
            ev_start = TBL[i].start; ev_done = TBL[i].done;
            ev_rx_mismatch = TBL[i].mis;
            ev_split_start = TBL[i].sst; ev_split_done = TBL[i].sdn;
            @(negedge clk);
            check_all($sformatf("vector %0d (R%0d)", i, TBL[i].req),
                      TBL[i].x_tog, TBL[i].x_busy, TBL[i].x_reg, TBL[i].x_eff, TBL[i].x_split);
        end

        // Directed: claim the pipe, open a split, then reset mid-flight.
        drive_idle();
        ev_start = 1; ev_split_start = 1; tog_set = 0;
        @(negedge clk);
        drive_idle();
        check_all("R3 claim before reset", 0, 1, 2'd1, 2'd1, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1 reset clears busy split field", 0, 0, 2'd0, 2'd0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 stays clear after release", 0, 0, 2'd0, 2'd0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule